// File: doc/BRIEF.md
# Periodic Rate Generator Counter

This block divides its clock by a programmed value N and marks each period with one low cycle on its output. After a control write clears it, the first count write loads the down-counter on the following clock edge. The counter then counts toward 1. The cycle in which it holds 1 drives the output low, and the next enabled edge reloads the count. The output is therefore low for one clock in every N. A count of 0 gives a period of 65536 clocks, and a count of 1 is reported as illegal.

The gate input does two jobs. While it is low, the counter holds its value and the output stays high. A low-to-high change on the gate restarts the period, so an external event can align the pulse train. A count written while the counter runs is held aside and used at the next reload, unless a gate trigger arrives first. In that case the new value loads at once. The whole block runs on one rising clock edge. The load that a slower, dual-edge counter would do on the falling edge is modelled here as one registered load stage.

Top module: `pulse_rate_divider`

## Requirements
- R1: After reset, and after a control write, `outSig` is high and `cntErr` is low. No low cycle appears until a count has been written.
- R2: When the first count N is written after a control write, the counter loads on the next edge. `outSig` is low in the cycle after the Nth rising edge that follows the edge sampling the write.
- R3: While the gate is high, `outSig` is low for exactly one cycle and repeats with a period of N cycles, indefinitely.
- R4: While the gate is low the counter holds its value and `outSig` stays high.
- R5: When the gate falls during the low cycle, `outSig` returns high in the same cycle, without waiting for a clock edge.
- R6: The first rising edge that samples the gate high after it was sampled low is a trigger. The initial count reloads on the next edge, and `outSig` is low N edges after the trigger edge. `outSig` is never low in the cycle in which the trigger is sampled.
- R7: A count written while counting leaves the current period unchanged. It sets the length of the periods that follow the next reload.
- R8: A trigger that arrives after a new count has been written loads the new count, so the next low cycle comes N_new edges after the trigger edge.
- R9: A count of 0 behaves as 65536: the first low cycle comes 65536 edges after the write edge.
- R10: Asserting `ctrlWr` forces `outSig` high in the same cycle and stops the counter. A count write in the same cycle is ignored, so no low cycle appears until a later count write.
- R11: The smallest legal count is 2. Writing 1 sets `cntErr` on the write edge. The flag stays set until a legal count is written or a control write occurs. A count of 2 gives alternating high and low cycles.
- R12: A count write sampled on the same edge as a terminal reload does not change the reload value. The old count sets the next period and the new one the period after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| gate | input | 1 | Count enable (level) and period restart (rising edge) |
| cntWr | input | 1 | Strobe: capture `cntData` as the initial count |
| ctrlWr | input | 1 | Strobe: reset the control logic and force the output high |
| cntData | input | 16 | Initial count; 0 means 65536 |
| outSig | output | 1 | Rate output, low for one clock per period |
| cntErr | output | 1 | Set while the captured count is the illegal value 1 |

## Verification
Two pairs of functions can land on the same clock edge. In the first, the terminal reload that ends a period meets a count write. In the second, a held count meets a gate trigger that arrives just after a new count write. The bench provokes the first pair by driving a write while `outSig` is low, so the write is sampled on the reload edge. It then checks that the low cycles fall first at the old spacing and then at the new one. It provokes the second pair by dropping the gate for one clock just after a new count write, and expects the next low cycle exactly N_new edges after the trigger edge.

// File: rtl/pulse_rate_divider_pkg.sv
package pulse_rate_divider_pkg;

  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic capture;  // take cntData into the holding register
    logic load;     // load counter from the holding register (start/trigger)
    logic reload;   // periodic reload at the terminal count
    logic dec;      // decrement by one
  } rg_strobe_t;

endpackage

// File: rtl/pulse_rate_divider_datapath.sv
module pulse_rate_divider_datapath
  import pulse_rate_divider_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rg_strobe_t       strobe,
  input  logic [WIDTH-1:0] cntData,
  output logic             cntIsOne
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] holdReg;
  logic [WIDTH-1:0] cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
      cntReg  <= '0;
    end else begin
      if (strobe.capture) begin
        holdReg <= cntData;
      end
      // reload uses the value held before this edge's capture
      if (strobe.load || strobe.reload) begin
        cntReg <= holdReg;
      end else if (strobe.dec) begin
        cntReg <= cntReg - ONE;  // 0 wraps to all ones: 2**WIDTH period
      end
    end
  end

  assign cntIsOne = (cntReg == ONE);

endmodule

// File: rtl/pulse_rate_divider_control.sv
module pulse_rate_divider_control
  import pulse_rate_divider_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gate,
  input  logic             cntWr,
  input  logic             ctrlWr,
  input  logic [WIDTH-1:0] cntData,
  input  logic             cntIsOne,
  output rg_strobe_t       strobe,
  output logic             outSig,
  output logic             cntErr
);

  localparam logic [WIDTH-1:0] BAD_COUNT = WIDTH'(1);

  logic armed;     // a count has been written since the last control write
  logic loadReq;   // one-cycle load stage pending
  logic gatePrev;  // gate as sampled on the previous edge
  logic errFlag;
  logic trig;
  logic run;

  assign trig = gate && !gatePrev;
  assign run  = armed && !loadReq && gate && !ctrlWr;

  always_comb begin
    strobe.capture = cntWr && !ctrlWr;
    strobe.load    = loadReq && !ctrlWr;
    strobe.reload  = run && cntIsOne;
    strobe.dec     = run && !cntIsOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      loadReq  <= 1'b0;
      gatePrev <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      gatePrev <= gate;
      if (ctrlWr) begin
        armed   <= 1'b0;
        loadReq <= 1'b0;
        errFlag <= 1'b0;
      end else begin
        loadReq <= (cntWr && !armed) || (trig && armed);
        if (cntWr) begin
          armed   <= 1'b1;
          errFlag <= (cntData == BAD_COUNT);
        end
      end
    end
  end

  // low only at terminal count with gate steadily high; gate fall or control write act at once
  assign outSig = !(armed && !loadReq && gate && gatePrev && cntIsOne && !ctrlWr);
  assign cntErr = errFlag;

endmodule

// File: rtl/pulse_rate_divider.sv
module pulse_rate_divider
  import pulse_rate_divider_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gate,
  input  logic             cntWr,
  input  logic             ctrlWr,
  input  logic [WIDTH-1:0] cntData,
  output logic             outSig,
  output logic             cntErr
);

  rg_strobe_t strobe;
  logic       cntIsOne;

  pulse_rate_divider_control #(.WIDTH(WIDTH)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .gate     (gate),
    .cntWr    (cntWr),
    .ctrlWr   (ctrlWr),
    .cntData  (cntData),
    .cntIsOne (cntIsOne),
    .strobe   (strobe),
    .outSig   (outSig),
    .cntErr   (cntErr)
  );

  pulse_rate_divider_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntData  (cntData),
    .cntIsOne (cntIsOne)
  );

endmodule

// File: rtl/pulse_rate_divider_chk.sv
module pulse_rate_divider_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             gate,
  input logic             cntWr,
  input logic             ctrlWr,
  input logic [WIDTH-1:0] cntData,
  input logic             outSig,
  input logic             cntErr
);

  AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rstN || cntErr)
    !outSig |=> outSig) else $error("single low cycle violated"); // R3

  AST_GATE_LOW_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !gate |-> outSig) else $error("output low with gate low"); // R4

  AST_TRIG_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gate) |-> outSig) else $error("output low in trigger cycle"); // R6

  AST_CTRL_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |-> outSig) else $error("control write did not force high"); // R10

  AST_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> outSig) else $error("output low right after control write"); // R10

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && !ctrlWr && cntData == WIDTH'(1)) |=> cntErr) else $error("count 1 not flagged"); // R11

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !cntErr) else $error("error not cleared by control write"); // R11

endmodule

bind pulse_rate_divider pulse_rate_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .gate    (gate),
  .cntWr   (cntWr),
  .ctrlWr  (ctrlWr),
  .cntData (cntData),
  .outSig  (outSig),
  .cntErr  (cntErr)
);

// File: tb/test_pulse_rate_divider.sv
`timescale 1ns/1ps
module test_pulse_rate_divider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        gate = 1'b1;
  logic        cntWr = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [15:0] cntData = '0;
  logic        outSig;
  logic        cntErr;

  int checks = 0;
  int fails = 0;
  int idx = 0;

  always #2 clk = ~clk;  // 250 MHz

  pulse_rate_divider #(.WIDTH(16)) i_pulse_rate_divider (
    .clk(clk), .rstN(rstN), .gate(gate), .cntWr(cntWr), .ctrlWr(ctrlWr),
    .cntData(cntData), .outSig(outSig), .cntErr(cntErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    idx++;
  endtask

  // write a count; returns just after the edge that sampled it, idx = 0
  task automatic writeCount(input int n);
    cntData = 16'(n);
    cntWr = 1'b1;
    step();
    cntWr = 1'b0;
    idx = 0;
  endtask

  task automatic ctrlWrite();
    ctrlWr = 1'b1;
    #1 chk(outSig == 1'b1, "R10 force high", int'(outSig), 1);
    step();
    ctrlWr = 1'b0;
  endtask

  // advance to target, expecting low exactly at idx lowA or lowB
  task automatic runTo(input int target, input int lowA, input int lowB, input string tag);
    while (idx < target) begin
      step();
      if (idx == lowA || idx == lowB)
        chk(outSig == 1'b0, tag, int'(outSig), 0);
      else
        chk(outSig == 1'b1, tag, int'(outSig), 1);
    end
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk(outSig == 1'b1, "R1 reset out", int'(outSig), 1);
    chk(cntErr == 1'b0, "R1 reset err", int'(cntErr), 0);
    rstN = 1'b1;
    step();
    idx = 0;
    runTo(6, -1, -1, "R1 idle no pulse");
    ctrlWrite();
    idx = 0;
    runTo(6, -1, -1, "R1 after ctrl no pulse");
  endtask

  task automatic tBasic();
    writeCount(3);
    chk(outSig == 1'b1, "R2 high after write", int'(outSig), 1);
    runTo(3, 3, -1, "R2 first low");
    runTo(9, 6, 9, "R3 period 3");
  endtask

  task automatic tFive();
    ctrlWrite();
    writeCount(5);
    runTo(10, 5, 10, "R3 period 5");
  endtask

  task automatic tMin();
    ctrlWrite();
    writeCount(2);
    runTo(4, 2, 4, "R11 count 2");
    runTo(8, 6, 8, "R11 count 2");
    chk(cntErr == 1'b0, "R11 count 2 legal", int'(cntErr), 0);
  endtask

  task automatic tHold();
    ctrlWrite();
    writeCount(4);
    runTo(2, -1, -1, "R4 before hold");
    gate = 1'b0;
    runTo(14, -1, -1, "R4 held high");
    gate = 1'b1;
    step();
    chk(outSig == 1'b1, "R6 trigger cycle high", int'(outSig), 1);
    idx = 0;
    runTo(8, 4, 8, "R6 restart after hold");
  endtask

  task automatic tGateFall();
    ctrlWrite();
    writeCount(3);
    runTo(3, 3, -1, "R5 reach low");
    gate = 1'b0;
    #1 chk(outSig == 1'b1, "R5 immediate high", int'(outSig), 1);
    step();
    chk(outSig == 1'b1, "R5 stays high", int'(outSig), 1);
    gate = 1'b1;
    step();
    idx = 0;
    runTo(6, 3, 6, "R6 trigger period");
  endtask

  task automatic tNewCount();
    ctrlWrite();
    writeCount(4);
    runTo(1, -1, -1, "R7 start");
    cntData = 16'd6;
    cntWr = 1'b1;
    step();
    cntWr = 1'b0;
    runTo(10, 4, 10, "R7 new count next period");
    runTo(16, 16, -1, "R7 new period");
  endtask

  task automatic tNewTrig();
    ctrlWrite();
    writeCount(4);
    runTo(1, -1, -1, "R8 start");
    cntData = 16'd7;
    cntWr = 1'b1;
    step();
    cntWr = 1'b0;
    gate = 1'b0;
    step();
    gate = 1'b1;
    step();
    idx = 0;
    runTo(14, 7, 14, "R8 trigger loads new count");
  endtask

  task automatic tSameEdge();
    ctrlWrite();
    writeCount(3);
    runTo(3, 3, -1, "R12 reach low");
    cntData = 16'd5;
    cntWr = 1'b1;
    step();
    cntWr = 1'b0;
    chk(outSig == 1'b1, "R12 after reload", int'(outSig), 1);
    runTo(11, 6, 11, "R12 old then new");
  endtask

  task automatic tCtrl();
    ctrlWrite();
    writeCount(3);
    runTo(3, 3, -1, "R10 reach low");
    ctrlWr = 1'b1;
    cntData = 16'd2;
    cntWr = 1'b1;
    #1 chk(outSig == 1'b1, "R10 immediate high", int'(outSig), 1);
    step();
    ctrlWr = 1'b0;
    cntWr = 1'b0;
    idx = 0;
    runTo(10, -1, -1, "R10 stopped, same-cycle write ignored");
  endtask

  task automatic tErr();
    ctrlWrite();
    writeCount(1);
    chk(cntErr == 1'b1, "R11 err set", int'(cntErr), 1);
    step();
    step();
    chk(cntErr == 1'b1, "R11 err held", int'(cntErr), 1);
    writeCount(3);
    chk(cntErr == 1'b0, "R11 err cleared by legal count", int'(cntErr), 0);
    ctrlWrite();
    writeCount(1);
    chk(cntErr == 1'b1, "R11 err set again", int'(cntErr), 1);
    ctrlWrite();
    chk(cntErr == 1'b0, "R11 err cleared by control", int'(cntErr), 0);
  endtask

  task automatic tZero();
    ctrlWrite();
    writeCount(0);
    runTo(65536, 65536, -1, "R9 count 0 is 65536");
    runTo(65538, -1, -1, "R9 after low");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    tReset();
    tBasic();
    tFive();
    tMin();
    tHold();
    tGateFall();
    tNewCount();
    tNewTrig();
    tSameEdge();
    tCtrl();
    tErr();
    tZero();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule